// File: doc/BRIEF.md
# Constant Divide-by-Three Quotient Unit

This block accepts an unsigned byte and returns the integer part of that byte divided by three. Any remainder is dropped. The quotient is computed twice, by two datapaths that share no logic. The first multiplies the operand by a fixed reciprocal constant using only wired shifts and adders, then drops the low product bits. The second is an unrolled long-division chain. A fixed divisor lets each bit stage replace its trial subtraction with a small logic function of a two-bit running remainder and one dividend bit.

One registered stage sits behind a simple valid strobe. The quotient port carries the reciprocal result. A flag reports any sample on which the two datapaths disagree. Because the two implementations are independent, the flag works as a built-in consistency monitor in a larger system.

Top module: `div3_quotient_unit`

## Requirements
- R1: For every operand 0..255 presented with `in_valid` high, `quotient` equals floor(operand / 3) on the cycle after the operand is accepted.
- R2: `out_valid` is high exactly one clock after a cycle in which `in_valid` was high, and low one clock after a cycle in which `in_valid` was low.
- R3: A synchronous active-high `rst` drives `out_valid`, `quotient` and `mismatch` to zero on the next clock edge, even when `in_valid` is high during that cycle.
- R4: Bit 7 of `quotient` is always 0, because the largest possible result is 85.
- R5: `mismatch` stays low for every operand, since both datapaths yield the same quotient.
- R6: While `in_valid` is low, `quotient` keeps the value it last took, and the data on `in_data` has no effect on it.
- R7: An operand of 61 yields a quotient of 20.
- R8: At the boundaries, operands 0, 1 and 2 yield 0, operand 3 yields 1, operand 254 yields 84 and operand 255 yields 85.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand on `in_data` is to be divided this cycle |
| in_data | input | 8 | Unsigned dividend |
| out_valid | output | 1 | `quotient` holds the result of the operand accepted one cycle earlier |
| quotient | output | 8 | Registered floor(dividend / 3), top bit always 0 |
| mismatch | output | 1 | Registered flag: the two internal datapaths disagreed on the accepted operand |

## Verification
The bench builds the block with its default 8-bit operand width. At that width the whole input space is only 256 values, so every operand is streamed back to back and compared against a behavioural integer division. With this width the factored three-adder reciprocal branch is the one elaborated, so that is the branch under test; the generic per-bit adder branch used for other widths is not built. Idle gaps filled with random data, a reset asserted in the middle of a valid stream, and the named boundary operands complete the stimulus.

// File: rtl/div3_pkg.sv
`timescale 1ns/1ps
package div3_pkg;

    // Two-bit running remainder of the long-division chain (value 0..2)
    typedef struct packed {
        logic hi;
        logic lo;
    } rem_t;

    // Result of one long-division bit stage
    typedef struct packed {
        logic qbit;
        rem_t rem;
    } ld_step_t;

    // Right shift applied after the reciprocal product
    function automatic int recip_shift(input int width);
        return width + 1;
    endfunction

    // ceil(2^shift / 3): the reciprocal constant
    function automatic int recip_const(input int width);
        return ((1 << recip_shift(width)) + 2) / 3;
    endfunction

    // One divide-by-three stage: the quotient bit is set when the
    // shifted-in value reaches 3, i.e. hi | (lo & incoming bit)
    function automatic ld_step_t ld_step(input rem_t r, input logic din);
        ld_step_t   res;
        logic [2:0] shifted;
        logic [2:0] reduced;
        shifted  = {r.hi, r.lo, din};
        res.qbit = r.hi | (r.lo & din);
        reduced  = res.qbit ? (shifted - 3'd3) : shifted;
        res.rem  = rem_t'(reduced[1:0]);
        return res;
    endfunction

endpackage

// File: rtl/div3_recip_path.sv
`timescale 1ns/1ps
module div3_recip_path
    import div3_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] x,
    output logic [W-1:0] q
);
    localparam int SH  = recip_shift(W);
    localparam int KC  = recip_const(W);
    localparam int PW  = W + SH;
    localparam logic [SH-1:0] KV = SH'(KC);

    logic [PW-1:0] prod;

    generate
        if (KC == 171 && SH == 9) begin : g_factored
            // 171 = 9 * 19 : three adders, all shifts are wiring
            logic [PW-1:0] xw;
            logic [PW-1:0] times9;
            assign xw     = PW'(x);
            assign times9 = xw + (xw << 3);
            assign prod   = times9 + (times9 << 1) + (times9 << 4);
        end else begin : g_bitsum
            // Generic constant multiply: one adder per set bit of the constant
            logic [PW-1:0] acc [0:SH];
            assign acc[0] = '0;
            for (genvar i = 0; i < SH; i++) begin : g_term
                if (KV[i]) begin : g_add
                    assign acc[i+1] = acc[i] + (PW'(x) << i);
                end else begin : g_pass
                    assign acc[i+1] = acc[i];
                end
            end
            assign prod = acc[SH];
        end
    endgenerate

    assign q = prod[SH +: W];

    // Reciprocal result lies within floor-division bounds
    localparam logic [W+1:0] THREE = 3;
    localparam logic [W+1:0] TWO   = 2;
    logic [W+1:0] q_times3;
    logic [W+1:0] x_ext;
    assign q_times3 = {2'b00, q} * THREE;
    assign x_ext    = {2'b00, x};

    assert_recip_floor_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (q_times3 <= x_ext) && (x_ext <= q_times3 + TWO));

endmodule

// File: rtl/div3_longdiv_path.sv
`timescale 1ns/1ps
module div3_longdiv_path
    import div3_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] x,
    output logic [W-1:0] q
);
    localparam int STAGES = W - 1;

    rem_t     rchain [0:STAGES];
    ld_step_t step   [0:STAGES-1];

    // Leading remainder: the top dividend bit alone, always below 3
    assign rchain[0] = '{hi: 1'b0, lo: x[W-1]};
    assign q[W-1]    = 1'b0;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            localparam int POS = W - 2 - s;
            assign step[s]     = ld_step(rchain[s], x[POS]);
            assign q[POS]      = step[s].qbit;
            assign rchain[s+1] = step[s].rem;
        end
    endgenerate

    // Quotient and final remainder reconstruct the dividend
    localparam logic [W+1:0] THREE = 3;
    logic [W+1:0] rebuilt;
    assign rebuilt = ({2'b00, q} * THREE) + {{W{1'b0}}, rchain[STAGES]};

    assert_longdiv_exact_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (rebuilt == {2'b00, x}) && (rchain[STAGES] != 2'b11));

endmodule

// File: rtl/div3_quotient_unit.sv
`timescale 1ns/1ps
module div3_quotient_unit
    import div3_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] quotient,
    output logic              mismatch
);
    logic [DATA_W-1:0] q_recip;
    logic [DATA_W-1:0] q_long;

    div3_recip_path #(.W(DATA_W)) u_recip (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .x        (in_data),
        .q        (q_recip)
    );

    div3_longdiv_path #(.W(DATA_W)) u_long (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .x        (in_data),
        .q        (q_long)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            quotient  <= '0;
            mismatch  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            mismatch  <= in_valid && (q_recip != q_long);
            if (in_valid) begin
                quotient <= q_recip;
            end
        end
    end

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_fall_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_reset_clears_R3: assert property (@(posedge clk)
        rst |=> (!out_valid && !mismatch && quotient == '0));
    assert_msb_clear_R4: assert property (@(posedge clk) disable iff (rst)
        !quotient[DATA_W-1]);
    assert_paths_agree_R5: assert property (@(posedge clk) disable iff (rst)
        !mismatch);
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(quotient));
    assert_example_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data == DATA_W'(61)) |=> (quotient == DATA_W'(20)));

endmodule

// File: tb/div3_quotient_unit_tb.sv
`timescale 1ns/1ps
module div3_quotient_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic       out_valid;
    logic [7:0] quotient;
    logic       mismatch;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Behavioural reference state: what the outputs must show after the next edge
    int m_valid = 0;
    int m_q     = 0;

    always #10 clk = ~clk;

    div3_quotient_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .quotient  (quotient),
        .mismatch  (mismatch)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
        end
    endtask

    // Check outputs of the previous edge, then drive the next cycle
    task automatic cycle(input bit r, input bit v, input int d, input string qtag);
        @(negedge clk);
        check(qtag == "R3" ? "R3" : "R2", int'(out_valid), m_valid);
        check(qtag, int'(quotient), m_q);
        check("R5", int'(mismatch), 0);
        check("R4", int'(quotient[7]), 0);
        rst      = r;
        in_valid = v;
        in_data  = 8'(d);
        if (r) begin
            m_valid = 0;
            m_q     = 0;
        end else begin
            m_valid = v ? 1 : 0;
            if (v) m_q = d / 3;
        end
    endtask

    initial begin
        // reset state
        repeat (3) cycle(1'b1, 1'b0, 0, "R3");
        // exhaustive sweep, back to back
        for (int i = 0; i < 256; i++) cycle(1'b0, 1'b1, i, "R1");
        cycle(1'b0, 1'b1, 61, "R1");
        cycle(1'b0, 1'b0, 7, "R7");
        // boundary operands
        cycle(1'b0, 1'b1, 0, "R6");
        cycle(1'b0, 1'b1, 1, "R8");
        cycle(1'b0, 1'b1, 2, "R8");
        cycle(1'b0, 1'b1, 3, "R8");
        cycle(1'b0, 1'b1, 254, "R8");
        cycle(1'b0, 1'b1, 255, "R8");
        // idle cycles with changing data: quotient must hold
        for (int i = 0; i < 8; i++) cycle(1'b0, 1'b0, int'($urandom_range(0, 255)), "R8");
        cycle(1'b0, 1'b1, 61, "R6");
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 255 - i, "R7");
        // random stream with sparse valids
        for (int i = 0; i < 60; i++)
            cycle(1'b0, 1'b1 & ($urandom_range(0, 2) != 0), int'($urandom_range(0, 255)), "R1");
        // reset in the middle of a valid stream
        cycle(1'b0, 1'b1, 200, "R1");
        cycle(1'b1, 1'b1, 150, "R1");
        cycle(1'b1, 1'b1, 90, "R3");
        cycle(1'b0, 1'b1, 99, "R3");
        cycle(1'b0, 1'b0, 0, "R1");
        cycle(1'b0, 1'b0, 0, "R6");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule